// File: doc/BRIEF.md
# Flash Command Interface Controller

This block sits between a host bus and the write engine of a word-wide boot-block flash array whose parameter region is at the top of the address space. Every host write strobe carries an address and a data word. The block decodes these writes as one-cycle commands (such as read-mode changes and status clearing) or as two-cycle commands (program and block erase). It keeps a status byte and chooses what a host read returns: array data, the status byte, or an identifier word.

Program and erase requests reach an abstract array port as level requests. Each request is held until the array returns a one-cycle done pulse. Before any program or erase starts, the target address is checked against a write-protect pin. When that pin is low, it locks the two highest 4-Kword parameter blocks. A refused attempt starts nothing and is flagged in the status byte.

An erase can be suspended. While it is suspended, a program may run. A later confirm code resumes the paused erase at its original block address. Read-mode, status-clear and repeated suspend commands may be issued in between without affecting the resume.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After a synchronous reset, the status byte reads 80h, reads return array data, and neither the program request nor the erase request is asserted.
- R2: The status byte holds ready (1 = idle) in bit 7, erase-suspended in bit 6, erase error in bit 5, program error in bit 4 and block-lock error in bit 1. Bits 0, 2 and 3 always read 0.
- R3: Writing FFh selects array reads, 70h selects status reads and 90h selects identifier reads. In identifier mode, a read with address bit 0 clear returns the maker code, and a read with address bit 0 set returns the device code.
- R4: Writing 40h or 10h, then a second write, raises the program request with that second write's address and data. The request is held until program-done. While the request is high, reads return status with ready at 0. Afterwards, reads return status.
- R5: Writing 20h, then D0h at an address, raises the erase request with that address until erase-done.
- R6: If the second cycle of an erase is not D0h, no erase starts, bits 5 and 4 are set, and the block returns to idle.
- R7: While the write-protect input is low, a program or erase whose target word address is at or above 1FE000h (blocks 69 and 70) does not start. A refused program sets bits 4 and 1; a refused erase sets bits 5 and 1.
- R8: With write-protect low, blocks 63 to 68 (1F8000h to 1FDFFFh) can still be programmed. With write-protect high, blocks 69 and 70 can be programmed.
- R9: Error bits stay set until a 50h write or a reset clears them. A new program is still accepted while they are set.
- R10: A command written while a program or erase is in progress has no effect, except B0h during an erase.
- R11: B0h during an erase drops the erase request. The status then shows ready and suspended (C0h).
- R12: While an erase is suspended, a program runs with the status showing suspended and not ready. A later D0h re-raises the erase request at the original block address. This also holds when FFh, 90h, 70h, 50h or B0h were written between the program and the D0h.
- R13: A reset during an operation drops all requests, clears the status byte to 80h and returns to array reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | One-cycle write strobe |
| bus_addr | input | 21 | Word address for writes and reads |
| bus_wdata | input | 16 | Write data; the low byte holds the command code |
| wp_n | input | 1 | Write protect; low locks the two top parameter blocks |
| rd_data | output | 16 | Read data for the current read mode and address |
| arr_rdata | input | 16 | Array data at bus_addr |
| arr_addr | output | 21 | Target address of the active program or erase |
| arr_wdata | output | 16 | Program data |
| arr_prog_req | output | 1 | Program request, held until done |
| arr_prog_done | input | 1 | One-cycle program-complete pulse |
| arr_erase_req | output | 1 | Erase request, held until done or suspend |
| arr_erase_done | input | 1 | One-cycle erase-complete pulse |

## Verification
A wrong sequencer state shows up on the cycle after the write that caused it. It appears either as a request line that is wrongly high or low, or as a status read with the wrong ready or suspended bit. A lost suspended-erase address only shows up when the erase is resumed, because arr_addr then differs from the original block. Sticky error bits are checked by reading the status again after later commands. This catches any path that clears them without a 50h write.

// File: rtl/fcc_pkg.sv
// Package: shared command codes, sequencer states and read modes for the
// flash command controller. Assumes 8-bit command codes in the low data byte.
package fcc_pkg;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CMD_READ_ID    = 8'h90;
    localparam logic [7:0] CMD_READ_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
    localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
    localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
    localparam logic [7:0] CMD_PROG_A     = 8'h40;
    localparam logic [7:0] CMD_PROG_B     = 8'h10;
    localparam logic [7:0] CMD_ERASE      = 8'h20;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PSETUP,
        ST_ESETUP,
        ST_PROG,
        ST_ERASE,
        ST_SUSP,
        ST_SPSETUP,
        ST_SPROG
    } seq_state_t;

    typedef enum logic [1:0] {
        RM_ARRAY,
        RM_STATUS,
        RM_IDENT
    } rd_mode_t;
endpackage

// File: rtl/fcc_lock_decode.sv
// Lock decoder: reports whether a word address falls in one of the top
// lockable parameter blocks. Assumes the parameter region fills the topmost
// main-block-sized slot, and that the locked block count is a power of two.
module fcc_lock_decode #(
    parameter int ADDR_W      = 21,
    parameter int MAIN_OFS_W  = 15,
    parameter int PARAM_OFS_W = 12,
    parameter int LOCK_BLKS   = 2,
    localparam int LOCK_LSB   = PARAM_OFS_W + $clog2(LOCK_BLKS)
) (
    input  logic [ADDR_W-1:LOCK_LSB] hi_addr,
    output logic                     in_locked
);
    // Locked when the address is in the parameter slot and its block index is among the top ones.
    always_comb begin
        in_locked = &hi_addr[ADDR_W-1:MAIN_OFS_W] && &hi_addr[MAIN_OFS_W-1:LOCK_LSB];
    end
endmodule

// File: rtl/fcc_status.sv
// Status byte: keeps the sticky error flags and combines them with the live
// ready and suspended flags. Assumes set and clear never arrive together.
module fcc_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_perr,
    input  logic       set_eerr,
    input  logic       set_lerr,
    input  logic       clr_err,
    input  logic       busy,
    input  logic       suspended,
    output logic [7:0] status
);
    logic perr_q, eerr_q, lerr_q;

    // Sticky error flags, cleared by the clear command or by reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_err) begin
            perr_q <= 1'b0;
            eerr_q <= 1'b0;
            lerr_q <= 1'b0;
        end else begin
            perr_q <= perr_q | set_perr;
            eerr_q <= eerr_q | set_eerr;
            lerr_q <= lerr_q | set_lerr;
        end
    end

    // Assemble the status byte from the live flags and the sticky flags.
    always_comb begin
        status = {~busy, suspended, eerr_q, perr_q, 2'b00, lerr_q, 1'b0};
    end
endmodule

// File: rtl/fcc_read_mux.sv
// Read selector: returns status while the array is busy; otherwise returns
// data for the current read mode. Assumes address bit 0 picks the identifier word.
module fcc_read_mux
    import fcc_pkg::*;
#(
    parameter int          DATA_W = 16,
    parameter logic [15:0] MFG_ID = 16'h0051,
    parameter logic [15:0] DEV_ID = 16'h88C4
) (
    input  rd_mode_t          mode,
    input  logic              busy,
    input  logic              id_sel,
    input  logic [7:0]        status,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rd_data
);
    // Select the read source.
    always_comb begin
        if (busy) begin
            rd_data = DATA_W'(status);
        end else begin
            case (mode)
                RM_ARRAY: rd_data = arr_rdata;
                RM_IDENT: rd_data = id_sel ? DATA_W'(DEV_ID) : DATA_W'(MFG_ID);
                default:  rd_data = DATA_W'(status);
            endcase
        end
    end
endmodule

// File: rtl/fcc_seq.sv
// Command sequencer: decodes bus writes and runs program, erase, suspend and
// resume. It latches the program and erase targets separately, so that a
// program inside a suspend keeps the erase address.
// Assumes bus_we is a one-cycle strobe and that done pulses come only while
// the matching request is high.
module fcc_seq
    import fcc_pkg::*;
#(
    parameter int ADDR_W = 21,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              blk_locked,
    input  logic              wp_n,
    input  logic              prog_done,
    input  logic              erase_done,
    output logic              prog_req,
    output logic              erase_req,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output rd_mode_t          mode,
    output logic              set_perr,
    output logic              set_eerr,
    output logic              set_lerr,
    output logic              clr_err,
    output logic              busy,
    output logic              suspended
);
    seq_state_t        st_q, st_n;
    rd_mode_t          mode_n;
    logic [ADDR_W-1:0] p_addr_q, e_addr_q;
    logic [DATA_W-1:0] p_data_q;
    logic              load_p, load_e;
    logic [7:0]        cmd;
    logic              lock_hit;

    assign cmd      = wdata[7:0];
    assign lock_hit = blk_locked & ~wp_n;

    // Next-state and command decode.
    always_comb begin
        st_n     = st_q;
        mode_n   = mode;
        set_perr = 1'b0;
        set_eerr = 1'b0;
        set_lerr = 1'b0;
        clr_err  = 1'b0;
        load_p   = 1'b0;
        load_e   = 1'b0;
        case (st_q)
            ST_IDLE: if (we) begin
                case (cmd)
                    CMD_READ_ARRAY: mode_n = RM_ARRAY;
                    CMD_READ_ID:    mode_n = RM_IDENT;
                    CMD_READ_STAT:  mode_n = RM_STATUS;
                    CMD_CLR_STAT:   clr_err = 1'b1;
                    CMD_PROG_A, CMD_PROG_B: begin
                        st_n = ST_PSETUP; mode_n = RM_STATUS;
                    end
                    CMD_ERASE: begin
                        st_n = ST_ESETUP; mode_n = RM_STATUS;
                    end
                    default: ;
                endcase
            end
            ST_PSETUP: if (we) begin
                if (lock_hit) begin
                    set_perr = 1'b1; set_lerr = 1'b1; st_n = ST_IDLE;
                end else begin
                    load_p = 1'b1; st_n = ST_PROG;
                end
            end
            ST_ESETUP: if (we) begin
                if (cmd != CMD_CONFIRM) begin
                    set_perr = 1'b1; set_eerr = 1'b1; st_n = ST_IDLE;
                end else if (lock_hit) begin
                    set_eerr = 1'b1; set_lerr = 1'b1; st_n = ST_IDLE;
                end else begin
                    load_e = 1'b1; st_n = ST_ERASE;
                end
            end
            ST_PROG: if (prog_done) st_n = ST_IDLE;
            ST_ERASE: begin
                if (erase_done) begin
                    st_n = ST_IDLE;
                end else if (we && cmd == CMD_SUSPEND) begin
                    st_n = ST_SUSP; mode_n = RM_STATUS;
                end
            end
            ST_SUSP: if (we) begin
                case (cmd)
                    CMD_READ_ARRAY: mode_n = RM_ARRAY;
                    CMD_READ_ID:    mode_n = RM_IDENT;
                    CMD_READ_STAT:  mode_n = RM_STATUS;
                    CMD_CLR_STAT:   clr_err = 1'b1;
                    CMD_CONFIRM: begin
                        st_n = ST_ERASE; mode_n = RM_STATUS;
                    end
                    CMD_PROG_A, CMD_PROG_B: begin
                        st_n = ST_SPSETUP; mode_n = RM_STATUS;
                    end
                    default: ;
                endcase
            end
            ST_SPSETUP: if (we) begin
                if (lock_hit) begin
                    set_perr = 1'b1; set_lerr = 1'b1; st_n = ST_SUSP;
                end else begin
                    load_p = 1'b1; st_n = ST_SPROG;
                end
            end
            ST_SPROG: if (prog_done) st_n = ST_SUSP;
            default: st_n = ST_IDLE;
        endcase
    end

    // State, read mode and target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            mode     <= RM_ARRAY;
            p_addr_q <= '0;
            p_data_q <= '0;
            e_addr_q <= '0;
        end else begin
            st_q <= st_n;
            mode <= mode_n;
            if (load_p) begin
                p_addr_q <= addr;
                p_data_q <= wdata;
            end
            if (load_e) e_addr_q <= addr;
        end
    end

    // Array-side outputs and condition flags.
    always_comb begin
        prog_req  = (st_q == ST_PROG) || (st_q == ST_SPROG);
        erase_req = (st_q == ST_ERASE);
        busy      = prog_req || erase_req;
        suspended = (st_q == ST_SUSP) || (st_q == ST_SPSETUP) || (st_q == ST_SPROG);
        arr_addr  = erase_req ? e_addr_q : p_addr_q;
        arr_wdata = p_data_q;
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Top of the flash command interface controller. Connects the lock decoder,
// sequencer, status byte and read selector. Assumes a single clock domain,
// a synchronous bus, and an array that pauses whenever its erase request drops.
module flash_cmd_ctrl
    import fcc_pkg::*;
#(
    parameter int ADDR_W      = 21,
    parameter int DATA_W      = 16,
    parameter int MAIN_OFS_W  = 15,
    parameter int PARAM_OFS_W = 12,
    parameter int LOCK_BLKS   = 2,
    localparam int LOCK_LSB   = PARAM_OFS_W + $clog2(LOCK_BLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              wp_n,
    output logic [DATA_W-1:0] rd_data,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    output logic              arr_prog_req,
    input  logic              arr_prog_done,
    output logic              arr_erase_req,
    input  logic              arr_erase_done
);
    logic       blk_locked;
    logic       set_perr, set_eerr, set_lerr, clr_err;
    logic       busy, suspended;
    logic [7:0] status_q;
    rd_mode_t   mode;

    fcc_lock_decode #(
        .ADDR_W(ADDR_W), .MAIN_OFS_W(MAIN_OFS_W),
        .PARAM_OFS_W(PARAM_OFS_W), .LOCK_BLKS(LOCK_BLKS)
    ) u_lock (
        .hi_addr  (bus_addr[ADDR_W-1:LOCK_LSB]),
        .in_locked(blk_locked)
    );

    fcc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .blk_locked(blk_locked),
        .wp_n      (wp_n),
        .prog_done (arr_prog_done),
        .erase_done(arr_erase_done),
        .prog_req  (arr_prog_req),
        .erase_req (arr_erase_req),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata),
        .mode      (mode),
        .set_perr  (set_perr),
        .set_eerr  (set_eerr),
        .set_lerr  (set_lerr),
        .clr_err   (clr_err),
        .busy      (busy),
        .suspended (suspended)
    );

    fcc_status u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_perr (set_perr),
        .set_eerr (set_eerr),
        .set_lerr (set_lerr),
        .clr_err  (clr_err),
        .busy     (busy),
        .suspended(suspended),
        .status   (status_q)
    );

    fcc_read_mux #(.DATA_W(DATA_W)) u_rd (
        .mode     (mode),
        .busy     (busy),
        .id_sel   (bus_addr[0]),
        .status   (status_q),
        .arr_rdata(arr_rdata),
        .rd_data  (rd_data)
    );
endmodule

// File: rtl/fcc_checker.sv
// Checker: timing properties of the command controller, attached by bind.
// Assumes the default address layout for the lock window.
module fcc_checker #(
    parameter int ADDR_W   = 21,
    parameter int LOCK_LSB = 13
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     prog_req,
    input logic                     erase_req,
    input logic [7:0]               status,
    input logic                     clr_err,
    input logic                     wp_n,
    input logic [ADDR_W-1:LOCK_LSB] hi_addr
);
    // R10: the array never sees program and erase together
    p_one_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_req && erase_req));

    // R4: ready reads 0 whenever a request is active
    p_busy_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req || erase_req) |-> !status[7]);

    // R11: a suspended erase never has its request raised
    p_susp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> !erase_req);

    // R9: erase error holds unless cleared
    p_sticky_eerr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !clr_err) |=> status[5]);

    // R7: a program never starts in a locked block while protected
    p_lock_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_req) |-> !((&hi_addr) && !$past(wp_n)));

    // R1: status starts out as ready with no flags
    p_reset_stat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (status == 8'h80));
endmodule

bind flash_cmd_ctrl fcc_checker #(.ADDR_W(ADDR_W), .LOCK_LSB(LOCK_LSB)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .prog_req (arr_prog_req),
    .erase_req(arr_erase_req),
    .status   (status_q),
    .clr_err  (clr_err),
    .wp_n     (wp_n),
    .hi_addr  (arr_addr[ADDR_W-1:LOCK_LSB])
);

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [20:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        wp_n = 1'b1;
    logic [15:0] rd_data;
    logic [15:0] arr_rdata = 16'hA5C3;
    logic [20:0] arr_addr;
    logic [15:0] arr_wdata;
    logic        arr_prog_req, arr_erase_req;
    logic        arr_prog_done = 1'b0, arr_erase_done = 1'b0;

    int vectors = 0;
    int errors  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flash_cmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .wp_n(wp_n), .rd_data(rd_data),
        .arr_rdata(arr_rdata), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
        .arr_prog_req(arr_prog_req), .arr_prog_done(arr_prog_done),
        .arr_erase_req(arr_erase_req), .arr_erase_done(arr_erase_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [20:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [20:0] a, input logic [15:0] exp);
        bus_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic pulse_pdone();
        @(negedge clk); arr_prog_done = 1'b1;
        @(negedge clk); arr_prog_done = 1'b0;
    endtask

    task automatic pulse_edone();
        @(negedge clk); arr_erase_done = 1'b1;
        @(negedge clk); arr_erase_done = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 prog_req", arr_prog_req, 0);
        chk("R1 erase_req", arr_erase_req, 0);
        rd_chk("R1 array read", 21'h000040, 16'hA5C3);
        wr(21'h0, 16'h0070);
        rd_chk("R1 R2 status after reset", 21'h0, 16'h0080);
    endtask

    task automatic t_read_modes();
        wr(21'h0, 16'h0090);
        rd_chk("R3 maker code", 21'h000000, 16'h0051);
        rd_chk("R3 device code", 21'h000001, 16'h88C4);
        wr(21'h0, 16'h00FF);
        rd_chk("R3 array", 21'h000001, 16'hA5C3);
        wr(21'h0, 16'h0070);
        rd_chk("R3 status", 21'h000001, 16'h0080);
    endtask

    task automatic t_program();
        wr(21'h0, 16'h0040);
        chk("R4 no req after setup", arr_prog_req, 0);
        wr(21'h001234, 16'hBEEF);
        chk("R4 prog_req", arr_prog_req, 1);
        chk("R4 addr", arr_addr, 21'h001234);
        chk("R4 data", arr_wdata, 16'hBEEF);
        rd_chk("R4 busy status", 21'h0, 16'h0000);
        pulse_pdone();
        chk("R4 req drops", arr_prog_req, 0);
        rd_chk("R4 R2 done status", 21'h0, 16'h0080);
        wr(21'h0, 16'h0010);
        wr(21'h000777, 16'h0101);
        chk("R4 alt code prog", arr_prog_req, 1);
        pulse_pdone();
    endtask

    task automatic t_erase();
        wr(21'h0, 16'h0020);
        wr(21'h018000, 16'h00D0);
        chk("R5 erase_req", arr_erase_req, 1);
        chk("R5 addr", arr_addr, 21'h018000);
        rd_chk("R5 busy status", 21'h0, 16'h0000);
        pulse_edone();
        chk("R5 req drops", arr_erase_req, 0);
        rd_chk("R5 done", 21'h0, 16'h0080);
    endtask

    task automatic t_erase_bad();
        wr(21'h0, 16'h0020);
        wr(21'h018000, 16'h00FF);
        chk("R6 no erase", arr_erase_req, 0);
        rd_chk("R6 R2 errors", 21'h0, 16'h00B0);
        wr(21'h0, 16'h0070);
        rd_chk("R9 still set", 21'h0, 16'h00B0);
        wr(21'h0, 16'h0040);
        wr(21'h000200, 16'h5555);
        chk("R9 prog accepted with errors", arr_prog_req, 1);
        rd_chk("R9 busy with errors", 21'h0, 16'h0030);
        pulse_pdone();
        rd_chk("R9 after prog", 21'h0, 16'h00B0);
        wr(21'h0, 16'h0050);
        rd_chk("R9 cleared", 21'h0, 16'h0080);
    endtask

    task automatic t_lock();
        wp_n = 1'b0;
        wr(21'h0, 16'h0040);
        wr(21'h1FE010, 16'h1111);
        chk("R7 locked prog no req", arr_prog_req, 0);
        rd_chk("R7 prog lock status", 21'h0, 16'h0092);
        wr(21'h0, 16'h0050);
        wr(21'h0, 16'h0020);
        wr(21'h1FF000, 16'h00D0);
        chk("R7 locked erase no req", arr_erase_req, 0);
        rd_chk("R7 erase lock status", 21'h0, 16'h00A2);
        wr(21'h0, 16'h0050);
        wr(21'h0, 16'h0040);
        wr(21'h1FD000, 16'h2222);
        chk("R8 block 68 open", arr_prog_req, 1);
        pulse_pdone();
        wr(21'h0, 16'h0040);
        wr(21'h1F8000, 16'h2323);
        chk("R8 block 63 open", arr_prog_req, 1);
        pulse_pdone();
        wp_n = 1'b1;
        wr(21'h0, 16'h0040);
        wr(21'h1FF000, 16'h3333);
        chk("R8 block 70 with wp high", arr_prog_req, 1);
        pulse_pdone();
        rd_chk("R8 no errors", 21'h0, 16'h0080);
    endtask

    task automatic t_busy_ignore();
        wr(21'h0, 16'h0040);
        wr(21'h000300, 16'h4444);
        wr(21'h0, 16'h00FF);
        wr(21'h0, 16'h0020);
        wr(21'h0, 16'h00B0);
        chk("R10 prog kept", arr_prog_req, 1);
        chk("R10 addr kept", arr_addr, 21'h000300);
        rd_chk("R10 no suspend", 21'h0, 16'h0000);
        pulse_pdone();
        rd_chk("R10 FF was ignored", 21'h0, 16'h0080);
    endtask

    task automatic t_suspend_resume();
        wr(21'h0, 16'h0020);
        wr(21'h010000, 16'h00D0);
        wr(21'h0, 16'h00B0);
        chk("R11 erase paused", arr_erase_req, 0);
        rd_chk("R11 suspended status", 21'h0, 16'h00C0);
        wr(21'h0, 16'h0040);
        wr(21'h000100, 16'h1234);
        chk("R12 prog in suspend", arr_prog_req, 1);
        chk("R12 prog addr", arr_addr, 21'h000100);
        rd_chk("R12 busy+susp", 21'h0, 16'h0040);
        pulse_pdone();
        rd_chk("R12 back to suspend", 21'h0, 16'h00C0);
        wr(21'h0, 16'h00FF);
        rd_chk("R12 array in suspend", 21'h0, 16'hA5C3);
        wr(21'h0, 16'h0090);
        wr(21'h0, 16'h0070);
        wr(21'h0, 16'h0050);
        wr(21'h0, 16'h00B0);
        wr(21'h0, 16'h00D0);
        chk("R12 resumed", arr_erase_req, 1);
        chk("R12 resume addr", arr_addr, 21'h010000);
        rd_chk("R12 resumed status", 21'h0, 16'h0000);
        pulse_edone();
        rd_chk("R12 erase done", 21'h0, 16'h0080);
    endtask

    task automatic t_reset_abort();
        wr(21'h0, 16'h0020);
        wr(21'h020000, 16'h00D0);
        chk("R13 erase running", arr_erase_req, 1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R13 aborted", arr_erase_req, 0);
        @(negedge clk); rst_n = 1'b1;
        rd_chk("R13 array mode", 21'h0, 16'hA5C3);
        wr(21'h0, 16'h0070);
        rd_chk("R13 status clear", 21'h0, 16'h0080);
    endtask

    initial begin
        t_reset();
        t_read_modes();
        t_program();
        t_erase();
        t_erase_bad();
        t_lock();
        t_busy_ignore();
        t_suspend_resume();
        t_reset_abort();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule